// File: doc/BRIEF.md
# Multi-format Stereo PCM Serial Receiver

This block turns a three-wire stereo PCM stream (bit clock, frame clock, serial data) into parallel samples. It runs in a fast system clock domain and oversamples the three serial lines through a synchronizer. It then finds the active bit-clock edge for the selected framing and assembles one left word and one right word per frame. Both words come out together with a single-cycle strobe. Samples are MSB first and two's complement, and every word is left-aligned into a 24-bit output with zeros in the unused low bits.

The framing and the word width come from a control register. Four framings are handled: I2S, left-justified, right-justified, and a DSP mode that marks each word with a frame-clock pulse. In right-justified mode the width sets where capture starts inside a 32-bit half-frame. In the other modes the width sets how many leading bits are kept. The system clock must run at least eight times the bit-clock rate.

Top module: `stereo_pcm_rx`

## Requirements
- R1: While rst_ni is low, left_o and right_o read zero and valid_o is low.
- R2: With fmt_i = 01 (left-justified), a frame-clock level of 1 marks left and 0 marks right. The MSB is the first bit after a frame-clock change, and bits are taken on rising bit-clock edges.
- R3: With fmt_i = 00 (I2S), a frame-clock level of 0 marks left and 1 marks right. The MSB is the second bit after a frame-clock change, and bits are taken on rising edges.
- R4: With fmt_i = 10 (right-justified), capture starts at bit index 32-W, counted from 0 at the frame-clock change. This is index 8, 12, 14 or 16 for W = 24, 20, 18 or 16. Bits are taken on rising edges.
- R5: With fmt_i = 11 (DSP), bits are taken on falling bit-clock edges. The MSB is the first bit sampled with the frame clock low after it was sampled high. The first word after reset is left, and later words alternate right and left.
- R6: width_i selects W: 00 = 24, 01 = 20, 10 = 18, 11 = 16. Only the first W bits of a word are kept and later bits are dropped. The result is left-aligned into 24 bits with zero low bits.
- R7: A word cut short by the next word start is committed with the bits received so far, left-aligned and zero-filled. This makes packed left-justified framing of 16 bit clocks per half-frame work at W = 24.
- R8: valid_o pulses for exactly one cycle when the right word of a frame completes. left_o and right_o change only in that cycle and hold otherwise.
- R9: Codes 00/00 give the default configuration, 24-bit I2S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Frame (word-select) clock |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| width_i | input | 2 | Word width: 00 24, 01 20, 10 18, 11 16 |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a frame completes |

## Verification
The bench puts junk ones after each word in the I2S, left-justified and DSP frames. A design that failed to truncate at W would show ones in the low bits. In right-justified mode a wrong start index shifts the word and shows up as a corrupted sample at every width. In DSP mode, two frames in a row check that the channel toggle restarts at left after reset, and that sampling happens on the falling edge; sampling on the wrong edge reads data one bit early. A packed 16-clock left-justified frame is sent at W = 24. It checks that a word cut short is committed at the next word start, and a design that waited for W bits would never strobe.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(24);
      2'd1:    return CNT_W'(20);
      2'd2:    return CNT_W'(18);
      default: return CNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic ws_i,
  input  logic sd_i,
  input  logic fall_active_i,
  output logic act_o,
  output logic ws_o,
  output logic sd_o
);
  logic [STAGES-1:0] sclk_q, ws_q, sd_q;
  logic              sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      ws_q   <= '0;
      sd_q   <= '0;
      sclk_d <= 1'b0;
      act_o  <= 1'b0;
      ws_o   <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      ws_q   <= {ws_q[STAGES-2:0], ws_i};
      sd_q   <= {sd_q[STAGES-2:0], sd_i};
      sclk_d <= sclk_q[STAGES-1];
      // ws/sd are registered alongside the edge strobe so they line up
      act_o  <= fall_active_i ? (sclk_d & ~sclk_q[STAGES-1])
                              : (~sclk_d & sclk_q[STAGES-1]);
      ws_o   <= ws_q[STAGES-1];
      sd_o   <= sd_q[STAGES-1];
    end
  end
endmodule

// File: rtl/spr_framer.sv
module spr_framer
  import spr_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  localparam int unsigned IDX_W    = $clog2(2 * SLOT_BITS),
  localparam int unsigned IDX_MAX  = 2 * SLOT_BITS - 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       ws_i,
  input  fmt_e       fmt_i,
  input  logic [1:0] width_i,
  output logic       start_o,
  output logic       win_o,
  output logic       left_o
);
  logic [IDX_W-1:0] idx_q, idx_eff, off;
  logic             ws_prev_q, primed_q, ch_q, dsp_tog_q, new_left;

  always_comb begin
    case (fmt_i)
      FMT_I2S: off = IDX_W'(1);
      FMT_RJ:  off = IDX_W'(SLOT_BITS) - IDX_W'(word_bits(width_i));
      default: off = '0;
    endcase

    if (fmt_i == FMT_DSP) start_o = act_i && ws_prev_q && !ws_i;
    else                  start_o = act_i && (!primed_q || (ws_i != ws_prev_q));

    case (fmt_i)
      FMT_I2S: new_left = ~ws_i;
      FMT_DSP: new_left = ~dsp_tog_q;
      default: new_left = ws_i;
    endcase

    if (start_o)                       idx_eff = '0;
    else if (idx_q == IDX_W'(IDX_MAX)) idx_eff = idx_q;
    else                               idx_eff = idx_q + 1'b1;

    win_o  = act_i && (idx_eff >= off) &&
             ((fmt_i != FMT_RJ) || (idx_eff < IDX_W'(SLOT_BITS)));
    left_o = start_o ? new_left : ch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      ws_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      ch_q      <= 1'b1;
      dsp_tog_q <= 1'b0;
    end else if (act_i) begin
      idx_q     <= idx_eff;
      ws_prev_q <= ws_i;
      primed_q  <= 1'b1;
      if (start_o) begin
        ch_q      <= new_left;
        dsp_tog_q <= ~dsp_tog_q;
      end
    end
  end
endmodule

// File: rtl/spr_assemble.sv
module spr_assemble
  import spr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  logic                start_i,
  input  logic                win_i,
  input  logic                left_i,
  input  logic                sd_i,
  input  logic [1:0]          width_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] acc_q, hold_q, base_acc, nxt_acc, cm_data;
  logic [CNT_W-1:0]    cnt_q, base_cnt, nxt_cnt, wb;
  logic                done_q, cur_left_q, base_done, base_left;
  logic                take, fin, flush, cm_en, cm_left;

  always_comb begin
    wb        = word_bits(width_i);
    base_acc  = start_i ? '0 : acc_q;
    base_cnt  = start_i ? '0 : cnt_q;
    base_done = start_i ? 1'b0 : done_q;
    base_left = start_i ? left_i : cur_left_q;
    take      = win_i && !base_done && (base_cnt < wb);
    nxt_acc   = base_acc;
    if (take) nxt_acc[SAMPLE_W-1-base_cnt] = sd_i;
    nxt_cnt   = base_cnt + CNT_W'(take);
    fin       = take && (nxt_cnt == wb);
    // a word cut short by the next start is flushed as received
    flush     = start_i && (cnt_q != '0) && !done_q;
    cm_en     = act_i && (fin || flush);
    cm_left   = flush ? cur_left_q : base_left;
    cm_data   = flush ? acc_q : nxt_acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      cur_left_q <= 1'b1;
      hold_q     <= '0;
      left_o     <= '0;
      right_o    <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (act_i) begin
        acc_q      <= nxt_acc;
        cnt_q      <= nxt_cnt;
        done_q     <= base_done | fin;
        cur_left_q <= base_left;
      end
      if (cm_en) begin
        if (cm_left) begin
          hold_q <= cm_data;
        end else begin
          left_o  <= hold_q;
          right_o <= cm_data;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stereo_pcm_rx.sv
module stereo_pcm_rx
  import spr_pkg::*;
#(
  parameter int unsigned SLOT_BITS   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          width_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  fmt_e fmt;
  logic act, ws_s, sd_s, start, win, left_ch;

  assign fmt = fmt_e'(fmt_i);

  spr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .ws_i, .sd_i,
    .fall_active_i(fmt == FMT_DSP),
    .act_o(act), .ws_o(ws_s), .sd_o(sd_s)
  );

  spr_framer #(.SLOT_BITS(SLOT_BITS)) u_framer (
    .clk_i, .rst_ni, .act_i(act), .ws_i(ws_s), .fmt_i(fmt), .width_i,
    .start_o(start), .win_o(win), .left_o(left_ch)
  );

  spr_assemble u_asm (
    .clk_i, .rst_ni, .act_i(act), .start_i(start), .win_i(win),
    .left_i(left_ch), .sd_i(sd_s), .width_i,
    .left_o, .right_o, .valid_o
  );
endmodule

// File: rtl/stereo_pcm_rx_chk.sv
module stereo_pcm_rx_chk
  import spr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          width_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o,
  input logic                act_i
);
  logic [SAMPLE_W-1:0] low_mask;
  assign low_mask = (SAMPLE_W'(1) << (CNT_W'(SAMPLE_W) - word_bits(width_i))) - 1'b1;

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_zero_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (((left_o & low_mask) == '0) && ((right_o & low_mask) == '0)));

  assert_valid_after_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(act_i));
endmodule

bind stereo_pcm_rx stereo_pcm_rx_chk u_chk (
  .clk_i, .rst_ni, .width_i, .left_o, .right_o, .valid_o, .act_i(act)
);

// File: tb/test_stereo_pcm_rx.sv
module test_stereo_pcm_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0, width_i = 2'd0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int errors = 0, checks = 0, vcnt = 0;
  logic [23:0] cap_l = '0, cap_r = '0;

  always #5 clk = ~clk;

  stereo_pcm_rx i_stereo_pcm_rx (
    .clk_i(clk), .rst_ni, .sclk_i, .ws_i, .sd_i, .fmt_i, .width_i,
    .left_o, .right_o, .valid_o
  );

  always @(negedge clk) if (valid_o) begin
    vcnt++;
    cap_l = left_o;
    cap_r = right_o;
  end

  // {fmt, width, left, right}
  localparam logic [51:0] VEC [10] = '{
    {2'd0, 2'd0, 24'hA5C3F1, 24'h3C0FE2},
    {2'd0, 2'd3, 24'h7FFFFF, 24'h800001},
    {2'd1, 2'd0, 24'h123456, 24'hFEDCBA},
    {2'd1, 2'd1, 24'hABCDEF, 24'h13579B},
    {2'd2, 2'd0, 24'hC0FFEE, 24'h0BADF0},
    {2'd2, 2'd2, 24'h5A5A5A, 24'hA5A5A5},
    {2'd2, 2'd3, 24'h8001FF, 24'h7FFE00},
    {2'd2, 2'd1, 24'hF0F0F0, 24'h0F0F0F},
    {2'd3, 2'd0, 24'h800000, 24'h7FFFFF},
    {2'd3, 2'd1, 24'hE1E1E1, 24'h1E1E1E}
  };

  function automatic int wbits(input logic [1:0] c);
    case (c) 2'd0: return 24; 2'd1: return 20; 2'd2: return 18; default: return 16; endcase
  endfunction

  function automatic logic [23:0] keep(input logic [23:0] v, input int w);
    return v & ~((24'h1 << (24 - w)) - 24'h1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    sclk_i = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input logic w, input logic d);
    sclk_i = (fmt_i == 2'd3);
    ws_i = w;
    sd_i = d;
    #40;
    sclk_i = (fmt_i != 2'd3);
    #40;
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
    int w;
    w = wbits(width_i);
    for (int b = 0; b < 64; b++) begin
      int hb;
      logic [23:0] v;
      logic wv, dv;
      hb = b % 32;
      v = (b < 32) ? l : r;
      case (fmt_i)
        2'd0: begin wv = (b >= 32); dv = (hb >= 1 && hb <= 24) ? v[24-hb] : 1'b1; end
        2'd1: begin wv = (b < 32);  dv = (hb < 24) ? v[23-hb] : 1'b1; end
        2'd2: begin wv = (b < 32);  dv = (hb >= 32 - w) ? v[23-(hb-(32-w))] : 1'b0; end
        default: begin wv = (hb == 0); dv = (hb >= 1 && hb <= 24) ? v[24-hb] : 1'b1; end
      endcase
      send_bit(wv, dv);
    end
    sclk_i = (fmt_i == 2'd3);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    chk(left_o == 0 && right_o == 0 && valid_o == 0, "R1 reset", left_o, 24'h0);
    do_reset();

    // vector walk: R2 LJ, R3 I2S, R4 RJ, R5 DSP, R6 width, R9 default (entry 0)
    for (int i = 0; i < 10; i++) begin
      logic [23:0] el, er;
      string rq;
      fmt_i   = VEC[i][51:50];
      width_i = VEC[i][49:48];
      do_reset();
      vcnt = 0;
      @(negedge clk);
      send_frame(VEC[i][47:24], VEC[i][23:0]);
      el = keep(VEC[i][47:24], wbits(width_i));
      er = keep(VEC[i][23:0], wbits(width_i));
      case (fmt_i)
        2'd0: rq = (i == 0) ? "R9 default/R3 I2S" : "R3 I2S/R6";
        2'd1: rq = "R2 LJ/R6";
        2'd2: rq = "R4 RJ/R6";
        default: rq = "R5 DSP/R6";
      endcase
      chk(vcnt == 1, {rq, " R8 one strobe"}, 24'(vcnt), 24'd1);
      chk(cap_l == el, {rq, " left"}, cap_l, el);
      chk(cap_r == er, {rq, " right"}, cap_r, er);
    end

    // R5: two DSP frames, channel order restarts at left and alternates
    fmt_i = 2'd3; width_i = 2'd0;
    do_reset();
    vcnt = 0;
    @(negedge clk);
    send_frame(24'h111111, 24'h222222);
    send_frame(24'h333333, 24'h444444);
    chk(vcnt == 2, "R5 two frames strobes", 24'(vcnt), 24'd2);
    chk(cap_l == 24'h333333, "R5 second left", cap_l, 24'h333333);
    chk(cap_r == 24'h444444, "R5 second right", cap_r, 24'h444444);

    // R7: packed LJ, 16 clocks per half at W=24
    fmt_i = 2'd1; width_i = 2'd0;
    do_reset();
    vcnt = 0;
    @(negedge clk);
    begin
      logic [15:0] pl, pr;
      pl = 16'hBEEF; pr = 16'h1357;
      for (int b = 0; b < 16; b++) send_bit(1'b1, pl[15-b]);
      for (int b = 0; b < 16; b++) send_bit(1'b0, pr[15-b]);
      send_bit(1'b1, 1'b0);
      sclk_i = 1'b0;
      repeat (12) @(negedge clk);
      chk(vcnt == 1, "R7 packed strobe", 24'(vcnt), 24'd1);
      chk(cap_l == {pl, 8'h00}, "R7 packed left", cap_l, {pl, 8'h00});
      chk(cap_r == {pr, 8'h00}, "R7 packed right", cap_r, {pr, 8'h00});
    end

    // R8: outputs hold with no traffic
    repeat (20) @(negedge clk);
    chk(left_o == 24'hBEEF00 && !valid_o, "R8 hold", left_o, 24'hBEEF00);

    // R1: reset clears outputs
    rst_ni = 1'b0;
    @(negedge clk);
    chk(left_o == 0 && right_o == 0 && !valid_o, "R1 reset after data", right_o, 24'h0);
    rst_ni = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule